// File: doc/BRIEF.md
# Filtered Bus Statistics Profiler

This block sits beside a slave bus port and watches its request/acknowledge handshake without driving anything back onto the bus. Over a programmable sample period it accumulates four statistics. Two byte-throughput totals count only accesses that pass a filter. The other two, a wait-cycle total and a transaction total, see all traffic. When the period ends, the block emits one record holding all four totals and their overflow flags, then starts the next period at once.

The two throughput totals each have their own master-ID select mask. They share one address window, one data-type filter (instruction, data, DMA) and one direction filter. A level cross-trigger input can be made to qualify counting. A small register port holds the period, the filters and the enables. A two-state controller (`ST_IDLE`, `ST_RUN`) gates the whole profiler. Transition T_START goes from `ST_IDLE` to `ST_RUN` when the export enable is set. Transition T_STOP goes back when it is cleared.

Top module: `bus_stat_profiler`

## Requirements
- R1: After reset, `rec_valid` is 0 and all record fields are 0. The period register reads 15, the control register reads 0, both master masks read 0, the window low bound reads 0 and the high bound reads all ones.
- R2: Control offset 0x08 bit 8 is the export enable. While it is set, a one-cycle `rec_valid` pulse occurs each time the period counter reaches the value held at offset 0x00. That is a period of value+1 cycles, with the counter starting from 0 in the first running cycle. While the bit is clear, no record is produced.
- R3: An access transfers in a cycle with `bus_req` and `bus_ack` both high. Throughput total k adds `bus_bytes` for each transferring access that passes the shared filter and whose `bus_mid` bit is set in mask k. Mask 0 is at offset 0x0C and mask 1 at offset 0x10.
- R4: The shared filter passes an access only when all three tests pass. The address must satisfy low ≤ address ≤ high, with low at 0x14 and high at 0x18. The data type must be enabled: code 0 instruction by control bit 1, code 1 data by bit 2, code 2 DMA by bit 3, and code 3 never passes. The direction must be enabled: reads (`bus_wr`=0) by bit 4, writes by bit 5.
- R5: The wait total adds one in each cycle with `bus_req` high and `bus_ack` low, regardless of any filter.
- R6: The access total adds one for each transferring access, regardless of any filter.
- R7: In the cycle the period expires, the record captures the totals from before that cycle. The totals restart holding only that cycle's contribution, so an access completing then counts in the new period.
- R8: Each total saturates at its maximum value instead of wrapping. `rec_ovf` bits 0..3 (throughput 0, throughput 1, wait, access) flag a saturation within the recorded period.
- R9: With control bit 0 set, the totals change only in cycles where `xtrig_in` is high. The period counter keeps running.
- R10: Clearing the export enable returns the block to idle, where the totals and the period counter are cleared. Setting it again starts a fresh period.
- R11: `cfg_rdata` returns the register at `cfg_addr` combinationally, showing only implemented bits. The control register keeps bits 0..5 and 8. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | monitored bus clock |
| rst_n | input | 1 | active-low reset |
| bus_req | input | 1 | master request pending |
| bus_ack | input | 1 | slave acknowledge |
| bus_mid | input | MID_W | master identifier |
| bus_addr | input | ADDR_W | access address |
| bus_dtype | input | 2 | 0 instruction, 1 data, 2 DMA |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_bytes | input | BYTE_W | bytes in the access |
| xtrig_in | input | 1 | level cross-trigger |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 8 | register byte offset |
| cfg_wdata | input | REG_W | register write data |
| cfg_rdata | output | REG_W | register read data |
| rec_valid | output | 1 | record strobe |
| rec_tput0 | output | CNT_W | throughput total 0 |
| rec_tput1 | output | CNT_W | throughput total 1 |
| rec_wait | output | CNT_W | wait-cycle total |
| rec_access | output | CNT_W | transaction total |
| rec_ovf | output | 4 | saturation flags |

## Verification
Several properties are checked on every cycle. An idle controller never produces a record, and a record always follows a running cycle. Totals never fall inside a period. A raised overflow flag implies a saturated total. When the trigger gates counting, the wait and access totals hold still. Whether the totals carry the right byte sums, whether the filters pick the right masters, windows, types and directions, and whether the expiry-cycle access lands in the new period can only be shown by the bench. It compares each emitted record against a cycle model built from the requirements.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bsp_state_e;

    typedef enum logic [1:0] {
        DT_INSN = 2'd0,
        DT_DATA = 2'd1,
        DT_DMA  = 2'd2,
        DT_RSVD = 2'd3
    } bsp_dtype_e;

    localparam int NUM_TP  = 2;
    localparam int NUM_CTR = 4;
    localparam int CI_WAIT = 2;
    localparam int CI_ACC  = 3;

    localparam logic [7:0] OFS_PERIOD    = 8'h00;
    localparam logic [7:0] OFS_CTRL      = 8'h08;
    localparam logic [7:0] OFS_MSEL_BASE = 8'h0C;
    localparam logic [7:0] OFS_ALO       = 8'h14;
    localparam logic [7:0] OFS_AHI       = 8'h18;

    localparam int CB_TRIGQ  = 0;
    localparam int CB_TINSN  = 1;
    localparam int CB_TDATA  = 2;
    localparam int CB_TDMA   = 3;
    localparam int CB_RD     = 4;
    localparam int CB_WR     = 5;
    localparam int CB_EXPORT = 8;
    localparam logic [31:0] CTRL_MASK = 32'h0000_013F;

endpackage

// File: rtl/bsp_regs.sv
module bsp_regs
    import bsp_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int PER_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int NUM_MID = 16,
    parameter int PER_RST = 15
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [7:0]                         addr,
    input  logic [REG_W-1:0]                   wdata,
    output logic [REG_W-1:0]                   rdata,
    output logic [PER_W-1:0]                   period_m1,
    output logic [REG_W-1:0]                   ctrl,
    output logic [NUM_TP-1:0][NUM_MID-1:0]     msel,
    output logic [ADDR_W-1:0]                  a_lo,
    output logic [ADDR_W-1:0]                  a_hi
);

    localparam logic [REG_W-1:0] CMASK = REG_W'(CTRL_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_m1 <= PER_W'(PER_RST);
            ctrl      <= '0;
            a_lo      <= '0;
            a_hi      <= '1;
        end else if (we) begin
            if (addr == OFS_PERIOD) period_m1 <= wdata[PER_W-1:0];
            if (addr == OFS_CTRL)   ctrl      <= wdata & CMASK;
            if (addr == OFS_ALO)    a_lo      <= wdata[ADDR_W-1:0];
            if (addr == OFS_AHI)    a_hi      <= wdata[ADDR_W-1:0];
        end
    end

    // one mask register per throughput total, at consecutive words
    for (genvar i = 0; i < NUM_TP; i++) begin : g_msel
        localparam logic [7:0] OFS_I = OFS_MSEL_BASE + 8'(4 * i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      msel[i] <= '0;
            else if (we && addr == OFS_I)    msel[i] <= wdata[NUM_MID-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_PERIOD) rdata = REG_W'(period_m1);
        if (addr == OFS_CTRL)   rdata = ctrl;
        if (addr == OFS_ALO)    rdata = REG_W'(a_lo);
        if (addr == OFS_AHI)    rdata = REG_W'(a_hi);
        for (int i = 0; i < NUM_TP; i++) begin
            if (addr == OFS_MSEL_BASE + 8'(4 * i)) rdata = REG_W'(msel[i]);
        end
    end

endmodule

// File: rtl/bsp_filter.sv
module bsp_filter
    import bsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MID_W  = 4,
    localparam int NUM_MID = 1 << MID_W
) (
    input  logic [MID_W-1:0]               mid,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [1:0]                     dtype,
    input  logic                           wr,
    input  logic [ADDR_W-1:0]              a_lo,
    input  logic [ADDR_W-1:0]              a_hi,
    input  logic [2:0]                     type_en,
    input  logic [1:0]                     dir_en,
    input  logic [NUM_TP-1:0][NUM_MID-1:0] msel,
    output logic [NUM_TP-1:0]              hit
);

    logic in_win;
    logic type_ok;
    logic dir_ok;
    logic shared_ok;

    always_comb begin
        unique case (bsp_dtype_e'(dtype))
            DT_INSN: type_ok = type_en[0];
            DT_DATA: type_ok = type_en[1];
            DT_DMA:  type_ok = type_en[2];
            DT_RSVD: type_ok = 1'b0;
        endcase
    end

    assign in_win    = (addr >= a_lo) && (addr <= a_hi);
    assign dir_ok    = wr ? dir_en[1] : dir_en[0];
    assign shared_ok = in_win && type_ok && dir_ok;

    for (genvar i = 0; i < NUM_TP; i++) begin : g_hit
        assign hit[i] = shared_ok && msel[i][mid];
    end

endmodule

// File: rtl/bsp_sat_ctr.sv
module bsp_sat_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restart,
    input  logic             en,
    input  logic [CNT_W-1:0] inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [CNT_W:0] sum;
    assign sum = {1'b0, cnt} + {1'b0, inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (restart) begin
            cnt <= en ? inc : '0;
            ovf <= 1'b0;
        end else if (en) begin
            if (sum[CNT_W]) begin
                cnt <= '1;
                ovf <= 1'b1;
            end else begin
                cnt <= sum[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/bus_stat_profiler.sv
module bus_stat_profiler
    import bsp_pkg::*;
#(
    parameter int MID_W   = 4,
    parameter int ADDR_W  = 32,
    parameter int BYTE_W  = 8,
    parameter int CNT_W   = 32,
    parameter int PER_W   = 16,
    parameter int REG_W   = 32,
    parameter int PER_RST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_ack,
    input  logic [MID_W-1:0]  bus_mid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_dtype,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_bytes,
    input  logic              xtrig_in,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              rec_valid,
    output logic [CNT_W-1:0]  rec_tput0,
    output logic [CNT_W-1:0]  rec_tput1,
    output logic [CNT_W-1:0]  rec_wait,
    output logic [CNT_W-1:0]  rec_access,
    output logic [3:0]        rec_ovf
);

    localparam int NUM_MID = 1 << MID_W;

    logic [PER_W-1:0]                 period_m1;
    logic [REG_W-1:0]                 ctrl;
    logic [NUM_TP-1:0][NUM_MID-1:0]   msel;
    logic [ADDR_W-1:0]                a_lo;
    logic [ADDR_W-1:0]                a_hi;
    logic [NUM_TP-1:0]                hit;

    bsp_state_e state_q;
    bsp_state_e state_d;
    logic       running;
    logic       gate;
    logic       expire;
    logic       trig_qual;
    logic       xfer;
    logic       stall;
    logic [PER_W-1:0] pcnt_q;

    logic [NUM_CTR-1:0][CNT_W-1:0] ctr_inc;
    logic [NUM_CTR-1:0]            ctr_en;
    logic [NUM_CTR-1:0][CNT_W-1:0] ctr_val;
    logic [NUM_CTR-1:0]            ctr_ovf;

    bsp_regs #(
        .REG_W   (REG_W),
        .PER_W   (PER_W),
        .ADDR_W  (ADDR_W),
        .NUM_MID (NUM_MID),
        .PER_RST (PER_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .period_m1 (period_m1),
        .ctrl      (ctrl),
        .msel      (msel),
        .a_lo      (a_lo),
        .a_hi      (a_hi)
    );

    bsp_filter #(
        .ADDR_W (ADDR_W),
        .MID_W  (MID_W)
    ) u_filter (
        .mid     (bus_mid),
        .addr    (bus_addr),
        .dtype   (bus_dtype),
        .wr      (bus_wr),
        .a_lo    (a_lo),
        .a_hi    (a_hi),
        .type_en ({ctrl[CB_TDMA], ctrl[CB_TDATA], ctrl[CB_TINSN]}),
        .dir_en  ({ctrl[CB_WR], ctrl[CB_RD]}),
        .msel    (msel),
        .hit     (hit)
    );

    // controller: next state (T_START / T_STOP)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl[CB_EXPORT])  state_d = ST_RUN;
            ST_RUN:  if (!ctrl[CB_EXPORT]) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // controller: per-state outputs
    always_comb begin
        running   = 1'b0;
        unique case (state_q)
            ST_IDLE: running = 1'b0;
            ST_RUN:  running = 1'b1;
        endcase
        trig_qual = ctrl[CB_TRIGQ];
        gate      = running && (!trig_qual || xtrig_in);
        expire    = running && (pcnt_q >= period_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pcnt_q <= '0;
        else if (!running || expire) pcnt_q <= '0;
        else                        pcnt_q <= pcnt_q + 1'b1;
    end

    assign xfer  = bus_req && bus_ack;
    assign stall = bus_req && !bus_ack;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        if (i < NUM_TP) begin : g_tput
            assign ctr_inc[i] = CNT_W'(bus_bytes);
            assign ctr_en[i]  = gate && xfer && hit[i];
        end else if (i == CI_WAIT) begin : g_wait
            assign ctr_inc[i] = CNT_W'(1);
            assign ctr_en[i]  = gate && stall;
        end else begin : g_acc
            assign ctr_inc[i] = CNT_W'(1);
            assign ctr_en[i]  = gate && xfer;
        end

        bsp_sat_ctr #(
            .CNT_W (CNT_W)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (!running),
            .restart (expire),
            .en      (ctr_en[i]),
            .inc     (ctr_inc[i]),
            .cnt     (ctr_val[i]),
            .ovf     (ctr_ovf[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_valid  <= 1'b0;
            rec_tput0  <= '0;
            rec_tput1  <= '0;
            rec_wait   <= '0;
            rec_access <= '0;
            rec_ovf    <= '0;
        end else begin
            rec_valid <= expire;
            if (expire) begin
                rec_tput0  <= ctr_val[0];
                rec_tput1  <= ctr_val[1];
                rec_wait   <= ctr_val[CI_WAIT];
                rec_access <= ctr_val[CI_ACC];
                rec_ovf    <= ctr_ovf;
            end
        end
    end

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker
    import bsp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input bsp_state_e                    state_q,
    input logic                          rec_valid,
    input logic                          expire,
    input logic                          trig_qual,
    input logic                          xtrig_in,
    input logic [NUM_CTR-1:0][CNT_W-1:0] ctr_val,
    input logic [NUM_CTR-1:0]            ctr_ovf
);

    p_idle_no_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |=> !rec_valid);

    p_rec_from_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(state_q) == ST_RUN);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr_chk
        p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_RUN && !expire) |=> ctr_val[i] >= $past(ctr_val[i]));

        p_ovf_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ctr_ovf[i] |-> ctr_val[i] == {CNT_W{1'b1}});
    end

    p_trig_hold_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && trig_qual && !xtrig_in && !expire) |=> $stable(ctr_val[CI_WAIT]));

    p_trig_hold_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && trig_qual && !xtrig_in && !expire) |=> $stable(ctr_val[CI_ACC]));

endmodule

bind bus_stat_profiler bsp_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .rec_valid (rec_valid),
    .expire    (expire),
    .trig_qual (trig_qual),
    .xtrig_in  (xtrig_in),
    .ctr_val   (ctr_val),
    .ctr_ovf   (ctr_ovf)
);

// File: tb/bus_stat_profiler_tb.sv
module bus_stat_profiler_tb;

    localparam int CNT_W = 10;
    localparam longint MAXV = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_ack = 0, bus_wr = 0, xtrig_in = 0;
    logic [3:0]  bus_mid = 0;
    logic [31:0] bus_addr = 0;
    logic [1:0]  bus_dtype = 0;
    logic [7:0]  bus_bytes = 0;
    logic        cfg_we = 0;
    logic [7:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        rec_valid;
    logic [CNT_W-1:0] rec_tput0, rec_tput1, rec_wait, rec_access;
    logic [3:0]  rec_ovf;

    always #2 clk = ~clk;

    bus_stat_profiler #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
        .bus_mid(bus_mid), .bus_addr(bus_addr), .bus_dtype(bus_dtype),
        .bus_wr(bus_wr), .bus_bytes(bus_bytes), .xtrig_in(xtrig_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rec_valid(rec_valid), .rec_tput0(rec_tput0),
        .rec_tput1(rec_tput1), .rec_wait(rec_wait), .rec_access(rec_access),
        .rec_ovf(rec_ovf)
    );

    typedef struct { longint c[4]; logic [3:0] ovf; } rec_t;
    rec_t exp_q[$];

    int n_cmp = 0, n_bad = 0, n_recs = 0;
    bit done = 0;
    string phase = "init";
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    // ---------------- reference model (from the requirements) ----------------
    logic [31:0] sh_per, sh_ctrl, sh_lo, sh_hi;
    logic [15:0] sh_msel [2];
    bit      m_run;
    longint  m_pcnt;
    longint  m_acc [4];
    bit      m_ovf [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            sh_per = 15; sh_ctrl = 0; sh_lo = 0; sh_hi = 32'hFFFF_FFFF;
            sh_msel[0] = 0; sh_msel[1] = 0;
            m_run = 0; m_pcnt = 0;
            for (int i = 0; i < 4; i++) begin m_acc[i] = 0; m_ovf[i] = 0; end
        end else begin
            if (m_run) begin
                bit gate, xfer, stall, sh_ok, tok;
                bit en [4];
                longint inc [4];
                rec_t r;
                gate  = !sh_ctrl[0] || xtrig_in;
                xfer  = bus_req && bus_ack;
                stall = bus_req && !bus_ack;
                case (bus_dtype)
                    2'd0: tok = sh_ctrl[1];   // R4 instruction
                    2'd1: tok = sh_ctrl[2];   // R4 data
                    2'd2: tok = sh_ctrl[3];   // R4 DMA
                    default: tok = 0;
                endcase
                sh_ok = bus_addr >= sh_lo && bus_addr <= sh_hi && tok &&
                        (bus_wr ? sh_ctrl[5] : sh_ctrl[4]);
                for (int k = 0; k < 2; k++) begin
                    en[k] = gate && xfer && sh_ok && sh_msel[k][bus_mid];
                    inc[k] = bus_bytes;
                end
                en[2] = gate && stall; inc[2] = 1;
                en[3] = gate && xfer;  inc[3] = 1;
                if (m_pcnt >= sh_per) begin      // R7 expiry
                    for (int i = 0; i < 4; i++) begin
                        r.c[i] = m_acc[i]; r.ovf[i] = m_ovf[i];
                        m_acc[i] = en[i] ? inc[i] : 0; m_ovf[i] = 0;
                    end
                    exp_q.push_back(r);
                    m_pcnt = 0;
                end else begin
                    for (int i = 0; i < 4; i++) begin
                        if (en[i]) begin
                            if (m_acc[i] + inc[i] > MAXV) begin
                                m_acc[i] = MAXV; m_ovf[i] = 1;
                            end else m_acc[i] = m_acc[i] + inc[i];
                        end
                    end
                    m_pcnt++;
                end
            end else begin
                m_pcnt = 0;
                for (int i = 0; i < 4; i++) begin m_acc[i] = 0; m_ovf[i] = 0; end
            end
            m_run = sh_ctrl[8];
            if (cfg_we) begin
                case (cfg_addr)
                    8'h00: sh_per = {16'h0, cfg_wdata[15:0]};
                    8'h08: sh_ctrl = cfg_wdata & 32'h13F;
                    8'h0C: sh_msel[0] = cfg_wdata[15:0];
                    8'h10: sh_msel[1] = cfg_wdata[15:0];
                    8'h14: sh_lo = cfg_wdata;
                    8'h18: sh_hi = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && rec_valid && !done) begin
            n_recs++;
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2 unexpected record [%s] actual=1 expected=0", phase);
            end else begin
                rec_t r;
                r = exp_q.pop_front();
                chk("R3 tput0",  rec_tput0,  r.c[0]);
                chk("R3 tput1",  rec_tput1,  r.c[1]);
                chk("R5 wait",   rec_wait,   r.c[2]);
                chk("R6 access", rec_access, r.c[3]);
                chk("R8 ovf",    rec_ovf,    r.ovf);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] e, string tag);
        cfg_addr = a; #1;
        chk(tag, cfg_rdata, e);
    endtask

    task automatic traffic(int n, int mode);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_mid   = lfsr[3:0];
            bus_dtype = lfsr[9:8];
            bus_wr    = lfsr[10];
            bus_addr  = 32'h80 + {22'h0, lfsr[15:7], 1'b0};
            xtrig_in  = lfsr[5] ^ lfsr[12];
            if (mode == 1) begin
                bus_req = 1; bus_ack = 1; bus_bytes = 8'hFF;
            end else begin
                bus_req   = lfsr[0] | lfsr[1];
                bus_ack   = bus_req & lfsr[2];
                bus_bytes = lfsr[15:8];
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        phase = "reset";
        chk("R1 rec_valid", rec_valid, 0);
        chk("R1 rec_tput0", rec_tput0, 0);
        chk("R1 rec_access", rec_access, 0);
        rd_chk(8'h00, 32'd15, "R1 period");
        rd_chk(8'h08, 32'd0, "R1 ctrl");
        rd_chk(8'h18, 32'hFFFF_FFFF, "R1 addr high");
        rd_chk(8'h0C, 32'd0, "R1 mask0");
        // R11: readback masks unimplemented bits
        phase = "R11";
        wr(8'h08, 32'hFFFF_FEFF);
        rd_chk(8'h08, 32'h0000_003F, "R11 ctrl bits");
        wr(8'h10, 32'hFFFF_F0F0);
        rd_chk(8'h10, 32'h0000_F0F0, "R11 mask1 width");
        rd_chk(8'h40, 32'h0, "R11 unmapped");

        // R2 R3 R5 R6 R7: mixed traffic, all types and directions
        phase = "R3 mixed";
        wr(8'h00, 7);
        wr(8'h0C, 32'h00FF);
        wr(8'h14, 32'h100);
        wr(8'h18, 32'h2FF);
        wr(8'h08, 32'h13E);
        traffic(64, 0);

        // R4: only DMA writes pass the shared filter
        phase = "R4 dma-write";
        wr(8'h08, 32'h128);
        traffic(48, 0);
        phase = "R4 insn-read";
        wr(8'h08, 32'h112);
        traffic(40, 0);

        // R9: trigger qualification, trigger toggling
        phase = "R9 trig";
        wr(8'h08, 32'h13F);
        traffic(48, 0);

        // R10: disabled -> no records, then fresh restart
        phase = "R10 off";
        wr(8'h08, 32'h03E);
        traffic(2, 0);
        snap = n_recs;
        traffic(24, 0);
        chk("R10 records while disabled", n_recs - snap, 0);
        phase = "R10 restart";
        wr(8'h08, 32'h13E);
        traffic(30, 0);

        // R8: saturation with full-size transfers every cycle
        phase = "R8 sat";
        wr(8'h00, 63);
        wr(8'h14, 0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF);
        traffic(140, 1);

        // R7: one-cycle period, every cycle is an expiry cycle
        phase = "R7 period1";
        wr(8'h00, 0);
        traffic(12, 0);
        phase = "R7 period3";
        wr(8'h00, 2);
        traffic(20, 0);

        phase = "drain";
        wr(8'h08, 32'h0);
        traffic(6, 0);
        chk("R2 all expected records seen", exp_q.size(), 0);
        chk("R2 records produced", n_recs > 20, 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule